// File: doc/BRIEF.md
# Warp Memory Request Coalescer

The block accepts one warp-wide memory request at a time. The request covers 32 lanes. Each lane has an active bit and a byte address for a 4-byte access. The block works out which 128-byte aligned lines the active lanes touch. For each distinct line it issues exactly one transaction, so a well-ordered warp costs a single memory access and a fully scattered warp costs one access per lane.

Each transaction carries two things: the line address, and a mask of the lanes that the line serves. Transactions leave one per cycle on a valid/ready handshake, and an output stays frozen while it is stalled. After the last transaction the block pulses `done` for one cycle. It then takes the next request.

The control is a three-state machine:
- `ST_IDLE` waits for a request and is the only state with `req_ready` high.
- `ST_ISSUE` presents one transaction per cycle for as long as lanes remain pending.
- `ST_DONE` holds `done` high for one cycle.

The transitions are:
- `ST_IDLE`→`ST_ISSUE` when a request with at least one active lane is accepted.
- `ST_IDLE`→`ST_DONE` when the accepted request has no active lanes.
- `ST_ISSUE`→`ST_ISSUE` after a handshake that leaves lanes pending, or while stalled.
- `ST_ISSUE`→`ST_DONE` after the handshake that serves the last pending lanes.
- `ST_DONE`→`ST_IDLE` unconditionally.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `req_ready` is 1, `txn_valid` is 0 and `done` is 0.
- R2: A lane's line is its byte address with the low 7 bits cleared. `txn_line` carries that full byte address of the line, with bits [6:0] equal to zero.
- R3: When active lane i addresses base + 4*i, with base 128-byte aligned, exactly one transaction is issued. Its mask has every active lane set.
- R4: When lane i addresses base + 128*i, 32 transactions are issued, each with exactly one mask bit set.
- R5: Transactions are ordered by the lowest-numbered lane still pending. Each transaction's mask has bit i set exactly for the pending lanes whose line equals that lane's line; mask bit i stands for lane i.
- R6: Inactive lanes are never set in any mask. Their addresses cause no transaction.
- R7: While `txn_valid` is 1 and `txn_ready` is 0, `txn_valid`, `txn_line` and `txn_mask` hold their values into the next cycle.
- R8: A request with no active lanes produces no transaction. `done` is 1 in the cycle after the request is accepted.
- R9: `done` is 1 for exactly one cycle, in the cycle after the handshake of the last transaction. `req_ready` is 0 from acceptance until `done` has been shown, and is 1 again in the following cycle.
- R10: Active lanes that share a line, including lanes with identical addresses, are served by one transaction.
- R11: The number of transactions equals the number of distinct lines among the active lanes. The masks are pairwise disjoint, and together they cover exactly the active lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block can take a request (idle) |
| req_active | input | 32 | Per-lane active bits, bit i = lane i |
| req_addr | input | 1024 | Lane byte addresses, lane i in bits [32*i+31:32*i] |
| txn_valid | output | 1 | Line transaction present |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_line | output | 32 | 128-byte aligned line byte address |
| txn_mask | output | 32 | Lanes served by this transaction |
| done | output | 1 | One-cycle pulse after the request is fully issued |

## Verification
The hardest situation to reach is a transaction that is stalled mid-sequence. Reaching it needs a partly drained pending set, several lanes aliasing one line, and a leader that is not lane 0, all at once while `txn_ready` is low.

The bench reaches it with a sweep of requests whose addresses are confined to a handful of lines. These requests have random active masks and random stalls on `txn_ready`. Each presented transaction is compared against a reference sequence computed lane by lane in the bench. Directed warps cover the contiguous, 128-byte stride, all-identical, empty and sparse cases.

// File: rtl/coal_pkg.sv
package coal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } coal_state_e;
endpackage

// File: rtl/coal_lane_store.sv
module coal_lane_store #(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int LINE_SHIFT = 7,
    localparam int LINE_W    = ADDR_W - LINE_SHIFT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_en,
    input  logic [LANES-1:0]         load_active,
    input  logic [LANES*ADDR_W-1:0]  load_addr,
    input  logic                     clear_en,
    input  logic [LANES-1:0]         clear_mask,
    output logic [LANES-1:0]         pending,
    output logic [LANES*LINE_W-1:0]  lines
);
    logic [LANES*LINE_SHIFT-1:0] offs_unused;
    logic                        unused_offs;

    // Pending set: loaded from the active bits, shrunk by each served mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pending <= '0;
        else if (load_en)
            pending <= load_active;
        else if (clear_en)
            pending <= pending & ~clear_mask;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign offs_unused[g*LINE_SHIFT +: LINE_SHIFT] =
            load_addr[g*ADDR_W +: LINE_SHIFT];

        // Only the line part of each address is kept
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lines[g*LINE_W +: LINE_W] <= '0;
            else if (load_en)
                lines[g*LINE_W +: LINE_W] <= load_addr[g*ADDR_W+LINE_SHIFT +: LINE_W];
        end
    end

    assign unused_offs = ^offs_unused;

    // Served lanes must have been pending
    AST_CLEAR_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        clear_en && !load_en |-> (clear_mask & ~pending) == '0);  // R11
endmodule

// File: rtl/coal_leader.sv
module coal_leader #(
    parameter int LANES   = 32,
    localparam int IDX_W  = $clog2(LANES)
) (
    input  logic [LANES-1:0] pending,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Lowest-numbered pending lane wins
    always_comb begin
        found = |pending;
        idx   = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i])
                idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/coal_match.sv
module coal_match #(
    parameter int LANES   = 32,
    parameter int LINE_W  = 25,
    localparam int IDX_W  = $clog2(LANES)
) (
    input  logic [LANES*LINE_W-1:0] lines,
    input  logic [LANES-1:0]        pending,
    input  logic [IDX_W-1:0]        idx,
    output logic [LINE_W-1:0]       leader_line,
    output logic [LANES-1:0]        mask
);
    assign leader_line = lines[idx*LINE_W +: LINE_W];

    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign mask[g] = pending[g] && (lines[g*LINE_W +: LINE_W] == leader_line);
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    localparam int LINE_SHIFT = $clog2(LINE_BYTES),
    localparam int LINE_W     = ADDR_W - LINE_SHIFT,
    localparam int IDX_W      = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES-1:0]        req_active,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_line,
    output logic [LANES-1:0]        txn_mask,
    output logic                    done
);
    coal_state_e state_q, state_d;

    logic                    accept;
    logic                    fire;
    logic [LANES-1:0]        pending;
    logic [LANES*LINE_W-1:0] lines;
    logic                    found;
    logic [IDX_W-1:0]        lead_idx;
    logic [LINE_W-1:0]       lead_line;
    logic [LANES-1:0]        match_mask;
    logic                    last_txn;

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign fire     = txn_valid && txn_ready;
    assign last_txn = (pending & ~match_mask) == '0;

    coal_lane_store #(
        .LANES(LANES), .ADDR_W(ADDR_W), .LINE_SHIFT(LINE_SHIFT)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .load_en(accept), .load_active(req_active), .load_addr(req_addr),
        .clear_en(fire), .clear_mask(match_mask),
        .pending(pending), .lines(lines)
    );

    coal_leader #(.LANES(LANES)) u_leader (
        .pending(pending), .found(found), .idx(lead_idx)
    );

    coal_match #(.LANES(LANES), .LINE_W(LINE_W)) u_match (
        .lines(lines), .pending(pending), .idx(lead_idx),
        .leader_line(lead_line), .mask(match_mask)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = (|req_active) ? ST_ISSUE : ST_DONE;
            ST_ISSUE: if (fire && last_txn) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        txn_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: txn_valid = 1'b1;
            ST_DONE:  done      = 1'b1;
            default:  req_ready = 1'b0;
        endcase
    end

    assign txn_line = {lead_line, {LINE_SHIFT{1'b0}}};
    assign txn_mask = match_mask;

    AST_ISSUE_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> found && txn_mask != '0);  // R5
    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> txn_line[LINE_SHIFT-1:0] == '0);  // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_line) && $stable(txn_mask));  // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);  // R9
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid || done) |-> !req_ready);  // R9
    AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fire && last_txn |=> done && !txn_valid);  // R9
    AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_active == '0 |=> done && !txn_valid);  // R8
endmodule

// File: tb/warp_coalescer_test.sv
module warp_coalescer_test;
    localparam int L = 32;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [L-1:0]  req_active = '0;
    logic [L*AW-1:0] req_addr = '0;
    logic          txn_valid;
    logic          txn_ready = 1'b0;
    logic [AW-1:0] txn_line;
    logic [L-1:0]  txn_mask;
    logic          done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [AW-1:0] a [L];
    logic [AW-1:0] exp_line [L];
    logic [L-1:0]  exp_mask [L];
    int            nexp;

    always #5 clk = ~clk;

    warp_coalescer uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_active(req_active), .req_addr(req_addr),
        .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_line(txn_line), .txn_mask(txn_mask), .done(done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference: leader-first grouping by line
    task automatic build_expected(input logic [L-1:0] act);
        logic [L-1:0] pend;
        pend = act;
        nexp = 0;
        while (pend != '0) begin
            int lead;
            logic [AW-1:0] ln;
            logic [L-1:0] m;
            lead = 0;
            for (int i = L - 1; i >= 0; i--) if (pend[i]) lead = i;
            ln = a[lead] & ~32'h7f;
            m = '0;
            for (int i = 0; i < L; i++)
                if (pend[i] && ((a[i] & ~32'h7f) == ln)) m[i] = 1'b1;
            exp_line[nexp] = ln;
            exp_mask[nexp] = m;
            nexp++;
            pend &= ~m;
        end
    endtask

    task automatic run_req(input logic [L-1:0] act, input int stall_mode, input string tag);
        int k;
        int guard;
        bit stalled;
        logic [L-1:0] cover_m;
        build_expected(act);
        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " R9 ready when idle"}, 64'(req_ready), 64'd1);
        for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = a[i];
        req_active = act;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        k = 0;
        stalled = 1'b0;
        cover_m = '0;
        guard = 0;
        while (!done && guard < 400) begin
            guard++;
            if (!txn_valid) begin
                chk(1'b0, {tag, " R9 neither valid nor done"}, 64'd0, 64'd1);
                break;
            end
            chk(req_ready == 1'b0, {tag, " R9 busy not ready"}, 64'(req_ready), 64'd0);
            if (k >= nexp) begin
                chk(1'b0, {tag, " R11 extra transaction"}, 64'(k), 64'(nexp));
                break;
            end
            chk(txn_line == exp_line[k], stalled ? {tag, " R7 line held"} : {tag, " R2 R5 line"},
                64'(txn_line), 64'(exp_line[k]));
            chk(txn_mask == exp_mask[k], stalled ? {tag, " R7 mask held"} : {tag, " R5 mask"},
                64'(txn_mask), 64'(exp_mask[k]));
            chk((txn_mask & ~act) == '0, {tag, " R6 inactive lane in mask"}, 64'(txn_mask), 64'(act));
            txn_ready = (stall_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
            stalled = !txn_ready;
            if (txn_ready) begin
                cover_m |= txn_mask;
                k++;
            end
            @(negedge clk);
        end
        txn_ready = 1'b0;
        chk(done == 1'b1 && txn_valid == 1'b0, {tag, (nexp == 0) ? " R8 done at once" : " R9 done after last"},
            64'({done, txn_valid}), 64'd2);
        chk(k == nexp, {tag, " R11 transaction count"}, 64'(k), 64'(nexp));
        chk(cover_m == act, {tag, " R11 masks cover active"}, 64'(cover_m), 64'(act));
        @(negedge clk);
        chk(done == 1'b0, {tag, " R9 done one cycle"}, 64'(done), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && txn_valid == 1'b0 && done == 1'b0, "R1 reset state",
            64'({req_ready, txn_valid, done}), 64'd4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && txn_valid == 1'b0 && done == 1'b0, "R1 after reset",
            64'({req_ready, txn_valid, done}), 64'd4);

        // R3 contiguous words
        for (int i = 0; i < L; i++) a[i] = 32'h0001_0000 + 32'(4 * i);
        run_req('1, 0, "R3 contiguous");
        chk(nexp == 1 && exp_mask[0] == '1, "R3 one line expected", 64'(nexp), 64'd1);

        // R4 128-byte stride
        for (int i = 0; i < L; i++) a[i] = 32'h0020_0000 + 32'(128 * i);
        run_req('1, 1, "R4 stride");
        chk(nexp == 32, "R4 32 transactions", 64'(nexp), 64'd32);

        // R10 identical addresses
        for (int i = 0; i < L; i++) a[i] = 32'hdead_be00;
        run_req('1, 1, "R10 same address");

        // R8 empty request
        run_req('0, 0, "R8 empty");

        // R6 sparse active, inactive lanes on distinct lines
        for (int i = 0; i < L; i++) a[i] = (i % 4 == 1) ? 32'h0000_4004 : 32'h0100_0000 + 32'(256 * i);
        run_req(32'h2222_2222, 1, "R6 sparse");

        // R5 reversed stride, leader order checked
        for (int i = 0; i < L; i++) a[i] = 32'h0300_0000 + 32'(128 * ((L - 1 - i) % 5)) + 32'(i % 32);
        run_req('1, 1, "R5 reversed");

        // Sweep: few lines, random active and stalls
        for (int t = 0; t < 400; t++) begin
            for (int i = 0; i < L; i++)
                a[i] = 32'h0400_0000 + 32'(($urandom % (1 + t % 6)) * 128) + 32'(($urandom % 32) * 4);
            run_req(32'($urandom) & 32'($urandom | 32'h0101_0101), t % 2, "R11 sweep");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule